// File: doc/BRIEF.md
# Chip Erase and Verify Sequencer

This block is a host-side controller that drives a complete chip erase of a byte-wide flash array. It issues commands and reads through a simple request/acknowledge bus master port. One start pulse runs the whole procedure. First the block asks an external program requester to bring every byte to 00h, so that the later erase acts evenly on all cells. It then writes the two-cycle erase command and waits a fixed number of clock cycles for the erase pulse. After that it checks the array one byte at a time. Each check writes the verify command together with the byte's address, waits a short settling time, reads the byte back and compares it with FFh.

When a byte does not read back as FFh, the sequencer keeps that byte's address and fires another erase pulse. It then continues checking from the same byte; it does not go back to address zero. Erase pulses are counted, and the count has an upper limit. When the count reaches that limit and a byte still fails, the run ends in failure. A run always finishes with a write of 00h, which puts the device back in read mode. After that write the sequencer gives a one-cycle done pulse and holds the pass or fail verdict. Both wait times, the last array address and the pulse limit are parameters, so a bench can run a small array with short waits.

Top module: `erase_verify_seq`

## Requirements
- R1: After an accepted start, `prog_req` goes high and stays high until `prog_ack` is seen. No bus command is issued before that.
- R2: The first two bus transactions after the program handshake are writes of data 20h. Every later erase pulse is also issued as a pair of 20h writes.
- R3: After the second 20h write of a pair is acknowledged, no further command is issued for at least `ERASE_WAIT` clock cycles.
- R4: Each byte check is a write of data A0h carrying the byte's address. It is followed, at least `VERIFY_WAIT` cycles later, by a read (`cmd_write` = 0) of the same address.
- R5: Checking starts at address 0 and moves up by one after each byte that reads FFh, up to `LAST_ADDR`.
- R6: A byte that reads anything other than FFh causes a new 20h/20h erase pulse. The next read after that pulse uses the same failing address.
- R7: The number of erase pulses in one run never exceeds `MAX_PULSES`. A mismatch seen after the last allowed pulse ends the run with `result_fail`.
- R8: Every run ends with a write of data 00h. When that write is acknowledged, `done` is high for exactly one cycle, and exactly one of `result_pass`/`result_fail` is set.
- R9: A `start` pulse that arrives while a run is in progress is ignored: it raises no second program request and does not change the pulse count.
- R10: After reset, `cmd_valid`, `prog_req`, `done`, `result_pass` and `result_fail` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins a chip erase run when idle |
| prog_req | output | 1 | Request to the external program-to-00h pass |
| prog_ack | input | 1 | Completion of the program-to-00h pass |
| cmd_valid | output | 1 | Bus transaction pending; held until `bus_ack` |
| cmd_write | output | 1 | 1 = command write, 0 = data read |
| cmd_addr | output | ADDR_W | Byte address of the transaction |
| cmd_data | output | 8 | Command byte for writes |
| bus_ack | input | 1 | Transaction accepted (read data valid with it) |
| rd_data | input | 8 | Data returned by a read |
| done | output | 1 | One-cycle pulse at the end of a run |
| result_pass | output | 1 | Every byte verified as FFh in the last run |
| result_fail | output | 1 | Pulse limit reached in the last run |

## Verification
The bench's memory model gives each byte its own count of erase pulses before it reads FFh. This gives the bench a full expected list of read addresses to compare against. A design that restarted checking at address zero after a re-erase would produce extra reads at the low addresses. A design that skipped the failing byte would be missing the repeat read of that address. Both show up as an address or count mismatch. A byte that never erases drives the run to the pulse limit. A limit compare that is off by one would give one pulse too many or too few before failing. A start pulse injected mid-run shows whether the design wrongly restarts its program request. The final 00h write and the single-cycle done pulse are checked on both passing and failing runs.

// File: rtl/evs_pkg.sv
package evs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PROG,
    ST_ESET,
    ST_EGO,
    ST_EWAIT,
    ST_VCMD,
    ST_VWAIT,
    ST_VRD,
    ST_FIN
  } evs_state_t;

  localparam logic [7:0] OP_READ   = 8'h00;
  localparam logic [7:0] OP_ERASE  = 8'h20;
  localparam logic [7:0] OP_VERIFY = 8'hA0;
  localparam logic [7:0] ERASED    = 8'hFF;

  function automatic logic is_bus_state(evs_state_t s);
    return (s == ST_ESET) || (s == ST_EGO) || (s == ST_VCMD) ||
           (s == ST_VRD)  || (s == ST_FIN);
  endfunction

  function automatic logic [7:0] opcode_of(evs_state_t s);
    case (s)
      ST_ESET, ST_EGO: return OP_ERASE;
      ST_VCMD:         return OP_VERIFY;
      default:         return OP_READ;
    endcase
  endfunction

endpackage

// File: rtl/evs_timer.sv
module evs_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R3
  timer_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (load && load_val != '0) |=> !expired);

endmodule

// File: rtl/evs_pulse_ctr.sv
module evs_pulse_ctr #(
  parameter int MAX_PULSES = 1000,
  localparam int PW = $clog2(MAX_PULSES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)                                cnt <= '0;
    else if (inc && cnt != PW'(MAX_PULSES))        cnt <= cnt + 1'b1;
  end

  assign at_limit = (cnt == PW'(MAX_PULSES));

  // R7
  pulse_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= PW'(MAX_PULSES));

  // R7
  pulse_over_chk: assert property (@(posedge clk) disable iff (rst)
    (at_limit && !clr) |=> at_limit);

endmodule

// File: rtl/evs_addr_track.sv
module evs_addr_track #(
  parameter int ADDR_W    = 17,
  parameter int LAST_ADDR = (1 << 17) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr,
  output logic              at_last
);
  always_ff @(posedge clk) begin
    if (rst || clr)            addr <= '0;
    else if (inc && !at_last)  addr <= addr + 1'b1;
  end

  assign at_last = (addr == ADDR_W'(LAST_ADDR));

  // R5
  addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    addr <= ADDR_W'(LAST_ADDR));

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!inc && !clr) |=> $stable(addr));

endmodule

// File: rtl/erase_verify_seq.sv
module erase_verify_seq
  import evs_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int LAST_ADDR   = (1 << 17) - 1,
  parameter int ERASE_WAIT  = 2000000,
  parameter int VERIFY_WAIT = 1200,
  parameter int MAX_PULSES  = 1000,
  localparam int WMAX = (ERASE_WAIT > VERIFY_WAIT) ? ERASE_WAIT : VERIFY_WAIT,
  localparam int TW   = $clog2(WMAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              prog_req,
  input  logic              prog_ack,
  output logic              cmd_valid,
  output logic              cmd_write,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        cmd_data,
  input  logic              bus_ack,
  input  logic [7:0]        rd_data,
  output logic              done,
  output logic              result_pass,
  output logic              result_fail
);
  evs_state_t state, state_n;

  logic          run_clr, go_ack, vcmd_ack, rd_ok, rd_bad, fin_ack;
  logic          tmr_load, tmr_exp, at_limit, at_last;
  logic [TW-1:0] tmr_val;
  logic          verdict, verdict_n;

  assign run_clr  = (state == ST_IDLE) && start;
  assign go_ack   = (state == ST_EGO)  && bus_ack;
  assign vcmd_ack = (state == ST_VCMD) && bus_ack;
  assign rd_ok    = (state == ST_VRD)  && bus_ack && (rd_data == ERASED);
  assign rd_bad   = (state == ST_VRD)  && bus_ack && (rd_data != ERASED);
  assign fin_ack  = (state == ST_FIN)  && bus_ack;
  assign tmr_load = go_ack || vcmd_ack;
  assign tmr_val  = go_ack ? TW'(ERASE_WAIT) : TW'(VERIFY_WAIT);

  evs_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  evs_pulse_ctr #(.MAX_PULSES(MAX_PULSES)) u_pulses (
    .clk(clk), .rst(rst), .clr(run_clr), .inc(go_ack), .at_limit(at_limit)
  );

  evs_addr_track #(.ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR)) u_addr (
    .clk(clk), .rst(rst), .clr(run_clr), .inc(rd_ok), .addr(cmd_addr), .at_last(at_last)
  );

  always_comb begin
    state_n   = state;
    verdict_n = verdict;
    case (state)
      ST_IDLE:  if (start) state_n = ST_PROG;
      ST_PROG:  if (prog_ack) state_n = ST_ESET;
      ST_ESET:  if (bus_ack) state_n = ST_EGO;
      ST_EGO:   if (bus_ack) state_n = ST_EWAIT;
      ST_EWAIT: if (tmr_exp) state_n = ST_VCMD;
      ST_VCMD:  if (bus_ack) state_n = ST_VWAIT;
      ST_VWAIT: if (tmr_exp) state_n = ST_VRD;
      ST_VRD: begin
        if (rd_ok) begin
          if (at_last) begin
            state_n   = ST_FIN;
            verdict_n = 1'b1;
          end else begin
            state_n = ST_VCMD;
          end
        end else if (rd_bad) begin
          if (at_limit) begin
            state_n   = ST_FIN;
            verdict_n = 1'b0;
          end else begin
            state_n = ST_ESET;
          end
        end
      end
      ST_FIN:   if (bus_ack) state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      verdict     <= 1'b0;
      prog_req    <= 1'b0;
      cmd_valid   <= 1'b0;
      cmd_write   <= 1'b0;
      cmd_data    <= 8'h00;
      done        <= 1'b0;
      result_pass <= 1'b0;
      result_fail <= 1'b0;
    end else begin
      state     <= state_n;
      verdict   <= verdict_n;
      prog_req  <= (state_n == ST_PROG);
      cmd_valid <= is_bus_state(state_n);
      cmd_write <= (state_n != ST_VRD);
      cmd_data  <= opcode_of(state_n);
      done      <= fin_ack;
      if (run_clr) begin
        result_pass <= 1'b0;
        result_fail <= 1'b0;
      end else if (fin_ack) begin
        result_pass <= verdict;
        result_fail <= !verdict;
      end
    end
  end

  // R1
  prog_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    prog_req |-> !cmd_valid);

  // R4
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !bus_ack) |=> (cmd_valid && $stable(cmd_data) && $stable(cmd_addr)
                                  && $stable(cmd_write)));

  // R8
  done_verdict_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (result_pass != result_fail));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && start) |=> !prog_req);

endmodule

// File: tb/erase_verify_seq_tb.sv
module erase_verify_seq_tb;
  localparam int AW    = 17;
  localparam int LAST  = 15;
  localparam int EW    = 20;
  localparam int VW    = 5;
  localparam int MAXP  = 4;
  localparam int LOGSZ = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, prog_ack = 1'b0, bus_ack = 1'b0;
  logic [7:0] rd_data = 8'h00;
  logic prog_req, cmd_valid, cmd_write, done, result_pass, result_fail;
  logic [AW-1:0] cmd_addr;
  logic [7:0] cmd_data;

  erase_verify_seq #(.ADDR_W(AW), .LAST_ADDR(LAST), .ERASE_WAIT(EW),
                     .VERIFY_WAIT(VW), .MAX_PULSES(MAXP)) u_dut (
    .clk(clk), .rst(rst), .start(start), .prog_req(prog_req), .prog_ack(prog_ack),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .bus_ack(bus_ack), .rd_data(rd_data), .done(done),
    .result_pass(result_pass), .result_fail(result_fail));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int need [LAST+1];
  int left [LAST+1];
  logic          lg_wr   [LOGSZ];
  logic [AW-1:0] lg_addr [LOGSZ];
  logic [7:0]    lg_data [LOGSZ];
  int            lg_cyc  [LOGSZ];
  int n_log = 0, done_cnt = 0, preq_rise = 0;
  logic setup_seen = 1'b0, preq_d = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // bus responder and flash model: one acknowledge per pending transaction
  always @(negedge clk) begin
    preq_d <= prog_req;
    if (prog_req && !preq_d) preq_rise <= preq_rise + 1;
    if (done) done_cnt <= done_cnt + 1;
    if (cmd_valid && !bus_ack && !rst) begin
      if (n_log < LOGSZ) begin
        lg_wr[n_log] = cmd_write; lg_addr[n_log] = cmd_addr;
        lg_data[n_log] = cmd_data; lg_cyc[n_log] = cyc;
        n_log = n_log + 1;
      end
      if (cmd_write) begin
        if (cmd_data == 8'h20 && setup_seen) begin
          for (int i = 0; i <= LAST; i++) if (left[i] > 0) left[i] = left[i] - 1;
          setup_seen = 1'b0;
        end else setup_seen = (cmd_data == 8'h20);
      end else begin
        rd_data <= (cmd_addr <= LAST && left[cmd_addr] == 0) ? 8'hFF : 8'hF7;
      end
      bus_ack <= 1'b1;
    end else bus_ack <= 1'b0;
  end

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // runs one erase with per-byte pulse needs; checks the whole transaction log
  task automatic run_case(string name, bit poke_start);
    int exp_rd [$];
    int p, a, pulses, ri, quiet_bad;
    bit exp_pass;
    for (int i = 0; i <= LAST; i++) left[i] = need[i];
    n_log = 0; done_cnt = 0; preq_rise = 0; setup_seen = 1'b0;
    p = 1; a = 0;
    forever begin
      exp_rd.push_back(a);
      if (need[a] <= p) begin
        if (a == LAST) begin exp_pass = 1'b1; break; end
        a++;
      end else if (p == MAXP) begin exp_pass = 1'b0; break; end
      else p++;
    end
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait (prog_req);
    quiet_bad = 0;
    repeat (10) @(negedge clk) if (cmd_valid || !prog_req) quiet_bad++;
    check("R1", {name, " bus quiet during program pass"}, quiet_bad, 0);
    prog_ack = 1'b1;
    @(negedge clk) prog_ack = 1'b0;
    if (poke_start) begin
      repeat (8) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (!done) @(negedge clk);
    repeat (4) @(negedge clk);
    check("R9", {name, " program requests per run"}, preq_rise, 1);
    check("R2", {name, " first write 20h"}, (lg_wr[0] && lg_data[0] == 8'h20), 1);
    check("R2", {name, " second write 20h"}, (lg_wr[1] && lg_data[1] == 8'h20), 1);
    pulses = 0; ri = 0;
    for (int k = 0; k < n_log; k++) begin
      if (k > 0 && lg_wr[k] && lg_data[k] == 8'h20 && lg_wr[k-1] && lg_data[k-1] == 8'h20) begin
        pulses++;
        if (k + 1 < n_log && lg_data[k+1] == 8'hA0)
          check("R3", {name, " erase wait"}, (lg_cyc[k+1] - lg_cyc[k]) >= EW, 1);
      end
      if (!lg_wr[k]) begin
        check("R4", {name, " read preceded by A0h same addr"},
              (k > 0 && lg_wr[k-1] && lg_data[k-1] == 8'hA0 && lg_addr[k-1] == lg_addr[k]), 1);
        check("R4", {name, " verify wait"}, (lg_cyc[k] - lg_cyc[k-1]) >= VW, 1);
        if (ri < exp_rd.size())
          check("R6", {name, " read address order"}, int'(lg_addr[k]), exp_rd[ri]);
        ri++;
      end
    end
    check("R5", {name, " number of verify reads"}, ri, exp_rd.size());
    check("R7", {name, " erase pulses"}, pulses, p);
    check("R8", {name, " final write 00h"}, (lg_wr[n_log-1] && lg_data[n_log-1] == 8'h00), 1);
    check("R8", {name, " done pulse count"}, done_cnt, 1);
    check("R8", {name, " pass flag"}, result_pass, exp_pass);
    check(exp_pass ? "R8" : "R7", {name, " fail flag"}, result_fail, !exp_pass);
  endtask

  task automatic t_reset();
    check("R10", "cmd_valid after reset", cmd_valid, 0);
    check("R10", "prog_req after reset", prog_req, 0);
    check("R10", "done after reset", done, 0);
    check("R10", "result flags after reset", result_pass | result_fail, 0);
  endtask

  task automatic t_clean();
    for (int i = 0; i <= LAST; i++) need[i] = 1;
    run_case("clean", 1'b0);
  endtask

  task automatic t_resume();
    for (int i = 0; i <= LAST; i++) need[i] = 1;
    need[7] = 3; need[12] = 2; need[LAST] = 2;
    run_case("resume", 1'b1);
  endtask

  task automatic t_limit();
    for (int i = 0; i <= LAST; i++) need[i] = 1;
    need[5] = 10;
    run_case("limit", 1'b0);
  endtask

  task automatic t_exact_limit();
    for (int i = 0; i <= LAST; i++) need[i] = 1;
    need[0] = MAXP;
    run_case("exact_limit", 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_clean();
    t_resume();
    t_limit();
    t_exact_limit();
    summary();
  end
endmodule